// File: doc/BRIEF.md
# Camera Flash Trigger Sequencer

This block times a flash lamp and its prelight from one trigger event that is locked to the camera frame. The trigger source can be the camera vertical sync or a separate trigger input. For the camera sync, software chooses whether a rising or a falling edge fires. For the separate input, a rising edge fires. Both inputs reach the edge detector through a two-flop synchroniser.

Software arms the sequencer with a single-cycle write. On the next qualifying trigger the prelight turns on. After a programmed number of clock cycles the flash turns on. The flash stays on for a programmed number of cycles, and then both lines turn off together. At that point the sequencer pulses a done strobe for one cycle and disarms itself. A software abort turns both lines off and returns the sequencer to idle. The active level of both lamp lines is set by one polarity input.

Top module: `flash_seq`

## Requirements
- R1: While reset is held and after it is released, flash_o and prelight_o sit at their inactive level (the inverse of active_high_i) and done_o is 0.
- R2: With alt_src_i=0 and fall_edge_i=0, a rising edge of cam_vsync_i while the sequencer is armed fires it. prelight_o goes active at the third rising clock edge after the input changes: two synchroniser stages and one output register.
- R3: With alt_src_i=0 and fall_edge_i=1, only a falling edge of cam_vsync_i fires the sequencer. A rising edge leaves the outputs inactive.
- R4: With alt_src_i=1, a rising edge of alt_trig_i fires the sequencer, with the same three-edge latency. Edges on cam_vsync_i have no effect.
- R5: flash_o goes active exactly delay_i clock cycles after prelight_o goes active. A delay_i of 0 makes both go active in the same cycle.
- R6: flash_o stays active for ontime_i cycles, or for 1 cycle when ontime_i is 0. prelight_o goes inactive in the same cycle as flash_o.
- R7: done_o is high for exactly one cycle, in the cycle in which the lamp lines go inactive at the end of a sequence. After that the sequencer is idle and needs a new arm before it can fire again.
- R8: A trigger edge that arrives while the sequencer is not armed is ignored. A trigger edge that arrives while a sequence is running is also ignored.
- R9: active_high_i=1 makes both lamp lines active-high. active_high_i=0 makes them active-low. The polarity applies combinationally at the outputs.
- R10: abort_i drives both lamp lines inactive at the next clock edge. The sequencer returns to idle, done_o is not pulsed, and no flash follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cam_vsync_i | input | 1 | Camera vertical sync, asynchronous |
| alt_trig_i | input | 1 | Alternate trigger source, asynchronous |
| arm_i | input | 1 | One-cycle arm request |
| abort_i | input | 1 | One-cycle abort request |
| fall_edge_i | input | 1 | 1 selects the falling edge of camera vsync |
| alt_src_i | input | 1 | 1 selects the alternate trigger input |
| active_high_i | input | 1 | Output polarity: 1 active-high, 0 active-low |
| delay_i | input | CNT_W | Prelight-to-flash delay in cycles |
| ontime_i | input | CNT_W | Flash on-time in cycles |
| flash_o | output | 1 | Flash lamp line |
| prelight_o | output | 1 | Prelight lamp line |
| done_o | output | 1 | One-cycle end-of-sequence strobe |

## Verification
Several properties are checked by assertions on every cycle:
- the flash is never on without the prelight;
- done is a single cycle and coincides with the flash turning off;
- an abort always leaves the lamp lines off at the next edge;
- the prelight can only start from the armed state.

Other behaviour can only be shown by the bench's scenarios. These are the exact three-edge trigger latency, the programmed delay and on-time counts including the zero cases, the choice of edge and source, the polarity inversion, and the fact that ignored triggers cause no output change. The bench's scoreboard checks each of these against the timestamp and the level of every output change.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_WAIT  = 2'd2,
        ST_FIRE  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/flash_trig_sync.sv
module flash_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din_i,
    input  logic fall_sel_i,
    output logic edge_o
);
    localparam int TOP = STAGES;

    logic [TOP:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[TOP-1:0], din_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    // sh_q[TOP-1] is the synchronised level, sh_q[TOP] its previous value
    assign edge_o = fall_sel_i ? (sh_q[TOP] & ~sh_q[TOP-1])
                               : (sh_q[TOP-1] & ~sh_q[TOP]);
endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
    import flash_seq_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic             abort_i,
    input  logic             trig_i,
    input  logic [CNT_W-1:0] delay_i,
    input  logic [CNT_W-1:0] ontime_i,
    output logic             flash_on_o,
    output logic             pre_on_o,
    output logic             done_o
);
    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             flash;
        logic             pre;
        logic             done;
    } seq_regs_t;

    seq_regs_t d, q;

    function automatic logic [CNT_W-1:0] on_load(input logic [CNT_W-1:0] n);
        return (n == '0) ? '0 : n - 1'b1;
    endfunction

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (abort_i) begin
            d.state = ST_IDLE;
            d.flash = 1'b0;
            d.pre   = 1'b0;
            d.cnt   = '0;
        end else begin
            unique case (q.state)
                ST_IDLE: begin
                    if (arm_i) d.state = ST_ARMED;
                end
                ST_ARMED: begin
                    if (trig_i) begin
                        d.pre = 1'b1;
                        if (delay_i == '0) begin
                            d.state = ST_FIRE;
                            d.flash = 1'b1;
                            d.cnt   = on_load(ontime_i);
                        end else begin
                            d.state = ST_WAIT;
                            d.cnt   = delay_i - 1'b1;
                        end
                    end
                end
                ST_WAIT: begin
                    if (q.cnt == '0) begin
                        d.state = ST_FIRE;
                        d.flash = 1'b1;
                        d.cnt   = on_load(ontime_i);
                    end else begin
                        d.cnt = q.cnt - 1'b1;
                    end
                end
                ST_FIRE: begin
                    if (q.cnt == '0) begin
                        d.state = ST_IDLE;
                        d.flash = 1'b0;
                        d.pre   = 1'b0;
                        d.done  = 1'b1;
                    end else begin
                        d.cnt = q.cnt - 1'b1;
                    end
                end
                default: d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= ST_IDLE;
            q.cnt   <= '0;
            q.flash <= 1'b0;
            q.pre   <= 1'b0;
            q.done  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign flash_on_o = q.flash;
    assign pre_on_o   = q.pre;
    assign done_o     = q.done;

    // R6
    pre_covers_flash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.flash |-> q.pre);

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);

    // R7
    done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> ($past(q.flash) && !q.flash && !q.pre));

    // R10
    abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> (!q.flash && !q.pre && !q.done));

    // R8
    fire_from_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.pre) |-> ($past(q.state) == ST_ARMED));
endmodule

// File: rtl/flash_seq.sv
module flash_seq #(
    parameter int CNT_W       = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cam_vsync_i,
    input  logic             alt_trig_i,
    input  logic             arm_i,
    input  logic             abort_i,
    input  logic             fall_edge_i,
    input  logic             alt_src_i,
    input  logic             active_high_i,
    input  logic [CNT_W-1:0] delay_i,
    input  logic [CNT_W-1:0] ontime_i,
    output logic             flash_o,
    output logic             prelight_o,
    output logic             done_o
);
    localparam int N_SRC = 2;

    logic [N_SRC-1:0] src_in, src_fall, src_edge;
    logic             trig;
    logic             flash_on, pre_on;

    assign src_in   = {alt_trig_i, cam_vsync_i};
    assign src_fall = {1'b0, fall_edge_i};

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        flash_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk        (clk),
            .rst_n      (rst_n),
            .din_i      (src_in[g]),
            .fall_sel_i (src_fall[g]),
            .edge_o     (src_edge[g])
        );
    end

    assign trig = alt_src_i ? src_edge[1] : src_edge[0];

    flash_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_i      (arm_i),
        .abort_i    (abort_i),
        .trig_i     (trig),
        .delay_i    (delay_i),
        .ontime_i   (ontime_i),
        .flash_on_o (flash_on),
        .pre_on_o   (pre_on),
        .done_o     (done_o)
    );

    assign flash_o    = active_high_i ? flash_on : ~flash_on;
    assign prelight_o = active_high_i ? pre_on   : ~pre_on;
endmodule

// File: tb/flash_seq_bench.sv
module flash_seq_bench;
    localparam int CW = 24;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0;
    logic cam_vsync = 1'b0, alt_trig = 1'b0, arm = 1'b0, abort_r = 1'b0;
    logic fall_edge = 1'b0, alt_src = 1'b0, act_hi = 1'b1;
    logic [CW-1:0] dly = '0, ont = '0;
    logic flash, pre, done;

    flash_seq #(.CNT_W(CW)) u_flash_seq (
        .clk(clk), .rst_n(rst_n), .cam_vsync_i(cam_vsync), .alt_trig_i(alt_trig),
        .arm_i(arm), .abort_i(abort_r), .fall_edge_i(fall_edge), .alt_src_i(alt_src),
        .active_high_i(act_hi), .delay_i(dly), .ontime_i(ont),
        .flash_o(flash), .prelight_o(pre), .done_o(done)
    );

    typedef struct {
        int    cyc;
        logic  fl;
        logic  pr;
        logic  dn;
        string tag;
    } item_t;

    item_t exp_q[$];
    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    logic  mon_en = 1'b0;
    logic [2:0] prev = 3'b000;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: every output change must match the next expected item
    always @(negedge clk) begin
        if (mon_en) begin
            if ({flash, pre, done} != prev) begin
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL unexpected change cyc=%0d act=%b exp=none", cyc, {flash, pre, done});
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    if (it.cyc != cyc || {it.fl, it.pr, it.dn} != {flash, pre, done}) begin
                        fails++;
                        $display("FAIL %s act cyc=%0d lvl=%b exp cyc=%0d lvl=%b",
                                 it.tag, cyc, {flash, pre, done}, it.cyc, {it.fl, it.pr, it.dn});
                    end
                end
            end
            prev = {flash, pre, done};
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic check(string tag, logic [2:0] act, logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%b exp=%b", tag, act, exp);
        end
    endtask

    task automatic check_empty(string tag);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL %s act pending=%0d exp=0", tag, exp_q.size());
        end
    endtask

    task automatic push(int c, logic f, logic p, logic d, string tag);
        item_t it;
        it.cyc = c; it.fl = f; it.pr = p; it.dn = d; it.tag = tag;
        exp_q.push_back(it);
    endtask

    // driver: expected sequence for a trigger applied in cycle c
    task automatic push_seq(int c, int d, int n);
        logic a, i;
        int t, m;
        a = act_hi; i = ~act_hi;
        t = c + 3;
        m = (n == 0) ? 1 : n;
        if (d == 0) push(t, a, a, 1'b0, "R2/R5 prelight+flash");
        else begin
            push(t, i, a, 1'b0, "R2 prelight on");
            push(t + d, a, a, 1'b0, "R5 flash on");
        end
        push(t + d + m, i, i, 1'b1, "R6/R7 lamps off + done");
        push(t + d + m + 1, i, i, 1'b0, "R7 done single");
    endtask

    task automatic do_arm();
        arm = 1'b1;
        tick(1);
        arm = 1'b0;
        tick(2);
    endtask

    initial begin
        tick(3);
        check("R1 reset held", {flash, pre, done}, 3'b000);
        rst_n = 1'b1;
        tick(2);
        check("R1 after reset", {flash, pre, done}, 3'b000);
        prev = 3'b000;
        mon_en = 1'b1;

        // rising vsync, delay 3, on-time 4
        dly = 24'd3; ont = 24'd4;
        do_arm();
        push_seq(cyc, 3, 4);
        cam_vsync = 1'b1;
        tick(20);
        cam_vsync = 1'b0;
        tick(10);
        check_empty("R2 R5 R6 sequence complete");

        // no arm after done: trigger ignored
        cam_vsync = 1'b1;
        tick(10);
        check("R7 idle after done", {flash, pre, done}, 3'b000);
        cam_vsync = 1'b0;
        tick(6);
        check_empty("R8 unarmed trigger");

        // falling edge select, zero delay and zero on-time
        fall_edge = 1'b1; dly = '0; ont = '0;
        do_arm();
        cam_vsync = 1'b1;
        tick(8);
        check("R3 rising ignored", {flash, pre, done}, 3'b000);
        push_seq(cyc, 0, 0);
        cam_vsync = 1'b0;
        tick(12);
        check_empty("R3 R5 R6 falling fire");

        // alternate source, vsync ignored, retrigger ignored
        fall_edge = 1'b0; alt_src = 1'b1; dly = 24'd5; ont = 24'd6;
        do_arm();
        cam_vsync = 1'b1;
        tick(4);
        cam_vsync = 1'b0;
        tick(6);
        check("R4 vsync ignored", {flash, pre, done}, 3'b000);
        push_seq(cyc, 5, 6);
        alt_trig = 1'b1;
        tick(4);
        alt_trig = 1'b0;
        tick(2);
        alt_trig = 1'b1;
        tick(24);
        alt_trig = 1'b0;
        tick(4);
        check_empty("R4 R8 alt fire, retrigger ignored");

        // active-low outputs
        alt_src = 1'b0; dly = 24'd1; ont = 24'd2;
        push(cyc, 1'b1, 1'b1, 1'b0, "R9 polarity flip");
        act_hi = 1'b0;
        tick(3);
        check("R9 idle active-low", {flash, pre, done}, 3'b110);
        do_arm();
        push_seq(cyc, 1, 2);
        cam_vsync = 1'b1;
        tick(15);
        check_empty("R9 active-low sequence");
        cam_vsync = 1'b0;
        tick(5);

        // abort during the delay phase
        dly = 24'd8; ont = 24'd4;
        do_arm();
        push(cyc + 3, 1'b1, 1'b0, 1'b0, "R10 prelight before abort");
        cam_vsync = 1'b1;
        tick(6);
        push(cyc + 1, 1'b1, 1'b1, 1'b0, "R10 abort clears");
        abort_r = 1'b1;
        tick(1);
        abort_r = 1'b0;
        tick(25);
        check_empty("R10 no flash after abort");
        cam_vsync = 1'b0;
        tick(4);
        cam_vsync = 1'b1;
        tick(8);
        check("R10 idle after abort", {flash, pre, done}, 3'b110);
        check_empty("R10 no activity after abort");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule